// File: doc/BRIEF.md
# Fractional Pulse-Swallow Clock Divider

This block thins a parent clock by letting through only `32 - N` of every 32 parent pulses, where `N` is a 5-bit rate code. It does not divide by an integer; it drops pulses. The result is a per-cycle pass enable. A downstream clock-gate cell turns that enable into the gated clock. The pass pulses are spread across each 32-slot window by a carry accumulator, so gaps stay as even as the ratio allows.

Two divider lanes share one rate word. The fast lane runs on every parent cycle. The slow lane runs on a parent divided by two, so it advances only on odd phase cycles. Software first writes both codes into a shadow copy. It then sets a commit bit in a separate command word. The hardware copies the shadow into the active codes at the next 64-cycle frame boundary. The commit bit stays set (reported as busy) until one further frame boundary has passed. While busy, the block ignores all writes.

Top module: `frac_swallow_div`

## Requirements
- R1: After synchronous reset both pass enables are 0, `busy` is 0 and the shadow readback is 0. The active codes are 0, so the block runs at full rate once reset is released.
- R2: With fast code N, the fast lane asserts `pass_en[0]` on exactly 32-N cycles of every 32-cycle window. The windows are aligned to reset release. N=0 passes every cycle; N=31 passes one cycle per window.
- R3: Within a window, slot s (0..31) of a lane with M = 32-N passes if and only if floor((s+1)·M/32) > floor(s·M/32).
- R4: The slow lane has one slot per two parent cycles. It can assert `pass_en[1]` only on odd cycles after reset release, and it passes 32-N of its 32 slots in every 64-cycle frame.
- R5: A write with `wr_sel`=0 loads the fast code from `wr_data[12:8]` and the slow code from `wr_data[4:0]`. All other data bits are ignored. `rate_rd` returns the codes at those same positions and zeros elsewhere.
- R6: A write with `wr_sel`=1 and `wr_data[31]`=1 while idle raises `busy` on the next cycle. The new codes first take effect at the next frame boundary, the edge closing a cycle whose phase is 63.
- R7: `busy` falls exactly one frame boundary after the transfer of the codes.
- R8: While `busy` is 1, rate writes and further commit writes are ignored. This includes a write that lands on the edge where `busy` falls.
- R9: A command-word write with bit 31 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the rate word, 1 selects the command word |
| wr_data | input | 32 | Write data |
| pass_en | output | 2 | Registered pass enables; bit 0 is the fast lane, bit 1 is the slow lane |
| busy | output | 1 | Commit pending (readback of the commit bit) |
| rate_rd | output | 32 | Shadow code readback |

## Verification
Two pairs of events can fall on the same clock edge. A commit write can land on the frame-end edge. A write can also arrive on the edge where `busy` is about to fall. The bench provokes the first by timing a commit so that its edge closes phase 63. The expected transfer then waits a full extra frame. It provokes the second by issuing rate writes on the last phase while the commit is still pending. A behavioural model running in lockstep decides each case from the state before the edge. It compares the pass enables, `busy` and the readback on every cycle. It also counts pulses per window.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic {SEL_RATE = 1'b0, SEL_CMD = 1'b1} wsel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_APPLIED} commit_e;
endpackage

// File: rtl/fsd_phase.sv
module fsd_phase #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            frame_end
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_q + 1'b1;
  end

  assign phase     = ph_q;
  assign frame_end = &ph_q;
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl #(
  parameter int SLOT_W   = 5,
  parameter int NUM_LANE = 2,
  parameter int STRIDE   = 8,
  parameter int WORD_W   = 32,
  parameter int KICK_BIT = 31
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic                               wr_sel,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic                               frame_end,
  output logic [NUM_LANE-1:0][SLOT_W-1:0]    shadow,
  output logic [NUM_LANE-1:0][SLOT_W-1:0]    active,
  output logic                               busy
);
  import fsd_pkg::*;

  commit_e st_q;
  logic    rate_wr, kick;

  assign rate_wr = wr_en && (wr_sel == SEL_RATE) && (st_q == ST_IDLE);
  assign kick    = wr_en && (wr_sel == SEL_CMD) && wr_data[KICK_BIT] && (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      shadow <= '0;
      active <= '0;
    end else begin
      for (int i = 0; i < NUM_LANE; i++)
        if (rate_wr) shadow[i] <= wr_data[STRIDE*(NUM_LANE-1-i) +: SLOT_W];
      case (st_q)
        ST_IDLE:    if (kick) st_q <= ST_ARMED;
        ST_ARMED:   if (frame_end) begin
                      active <= shadow;
                      st_q   <= ST_APPLIED;
                    end
        ST_APPLIED: if (frame_end) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/fsd_lane.sv
module fsd_lane #(
  parameter int SLOT_W = 5,
  parameter int PH_W   = 6,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   phase,
  input  logic [SLOT_W-1:0] code,
  output logic              pass_en
);
  localparam logic [SLOT_W:0] FULL = SLOT_W'(1) << SLOT_W;

  logic              tick;
  logic [SLOT_W-1:0] slot, acc_q, acc_base;
  logic [SLOT_W:0]   mult, sum;
  logic              en_q;

  generate
    if (IDX == 0) begin : g_full
      assign tick = 1'b1;
    end else begin : g_pre
      assign tick = &phase[IDX-1:0];
    end
  endgenerate

  assign slot     = phase[IDX +: SLOT_W];
  assign mult     = FULL - {1'b0, code};
  assign acc_base = (slot == '0) ? '0 : acc_q;
  assign sum      = {1'b0, acc_base} + mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= tick & sum[SLOT_W];
      if (tick) acc_q <= sum[SLOT_W-1:0];
    end
  end

  assign pass_en = en_q;
endmodule

// File: rtl/frac_swallow_div.sv
module frac_swallow_div #(
  parameter int SLOT_W   = 5,
  parameter int NUM_LANE = 2,
  parameter int STRIDE   = 8,
  parameter int WORD_W   = 32,
  parameter int KICK_BIT = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [NUM_LANE-1:0] pass_en,
  output logic                busy,
  output logic [WORD_W-1:0]   rate_rd
);
  localparam int PH_W = SLOT_W + NUM_LANE - 1;

  logic [PH_W-1:0]                    phase;
  logic                               frame_end;
  logic [NUM_LANE-1:0][SLOT_W-1:0]    shadow;
  logic [NUM_LANE-1:0][SLOT_W-1:0]    act_codes;

  fsd_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .frame_end(frame_end)
  );

  fsd_ctrl #(
    .SLOT_W(SLOT_W), .NUM_LANE(NUM_LANE), .STRIDE(STRIDE),
    .WORD_W(WORD_W), .KICK_BIT(KICK_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .frame_end(frame_end), .shadow(shadow), .active(act_codes), .busy(busy)
  );

  generate
    for (genvar i = 0; i < NUM_LANE; i++) begin : g_lane
      fsd_lane #(.SLOT_W(SLOT_W), .PH_W(PH_W), .IDX(i)) u_lane (
        .clk(clk), .rst(rst), .phase(phase), .code(act_codes[i]),
        .pass_en(pass_en[i])
      );
    end
  endgenerate

  always_comb begin
    rate_rd = '0;
    for (int i = 0; i < NUM_LANE; i++)
      rate_rd[STRIDE*(NUM_LANE-1-i) +: SLOT_W] = shadow[i];
  end
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
  parameter int SLOT_W   = 5,
  parameter int NUM_LANE = 2,
  parameter int WORD_W   = 32,
  parameter int KICK_BIT = 31
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic                         wr_sel,
  input logic [WORD_W-1:0]            wr_data,
  input logic [NUM_LANE-1:0]          pass_en,
  input logic                         busy,
  input logic [WORD_W-1:0]            rate_rd,
  input logic                         frame_end,
  input logic [NUM_LANE*SLOT_W-1:0]   act_flat
);
  logic kick_req;
  assign kick_req = wr_en && wr_sel && wr_data[KICK_BIT];

  AST_SLOW_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    pass_en[1] |=> !pass_en[1]);                                   // R4
  AST_SHADOW_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rate_rd));                                    // R8
  AST_KICK_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (kick_req && !busy) |=> busy);                                 // R6
  AST_NO_SPURIOUS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && !kick_req) |=> !busy);                               // R9
  AST_ACTIVE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(act_flat));                             // R6
  AST_BUSY_FALL_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(frame_end));                             // R7
endmodule

bind frac_swallow_div fsd_checker #(
  .SLOT_W(SLOT_W), .NUM_LANE(NUM_LANE), .WORD_W(WORD_W), .KICK_BIT(KICK_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .pass_en(pass_en), .busy(busy), .rate_rd(rate_rd), .frame_end(frame_end),
  .act_flat(act_codes)
);

// File: tb/frac_swallow_div_bench.sv
module frac_swallow_div_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pass_en;
  logic        busy;
  logic [31:0] rate_rd;

  int total = 0, bad = 0;
  bit done = 0;

  frac_swallow_div u_frac_swallow_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pass_en(pass_en), .busy(busy), .rate_rd(rate_rd)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_sh0, m_sh1, m_act0, m_act1, m_st, kcnt, last_ph;
  bit live;
  bit e_fast, e_slow;
  int wexp_f, wexp_s, wcnt_f, wcnt_s;

  function automatic bit slot_pass(int s, int m);
    return ((s + 1) * m) / 32 > (s * m) / 32;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sh0 = 0; m_sh1 = 0; m_act0 = 0; m_act1 = 0; m_st = 0; kcnt = 0; live = 0;
    end else begin
      int ph, old_st;
      ph = kcnt % 64;
      last_ph = ph;
      e_fast = slot_pass(ph % 32, 32 - m_act0);
      e_slow = (ph % 2 == 1) && slot_pass(ph / 2, 32 - m_act1);
      if (ph % 32 == 0) wexp_f = 32 - m_act0;
      if (ph == 0) wexp_s = 32 - m_act1;
      old_st = m_st;
      if (ph == 63) begin
        if (m_st == 1) begin m_act0 = m_sh0; m_act1 = m_sh1; m_st = 2; end
        else if (m_st == 2) m_st = 0;
      end
      if (wr_en && old_st == 0) begin
        if (!wr_sel) begin m_sh0 = wr_data[12:8]; m_sh1 = wr_data[4:0]; end
        else if (wr_data[31]) m_st = 1;
      end
      kcnt++;
      live = 1;
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      chk(pass_en[0] == e_fast, "R3 fast slot", pass_en[0], e_fast);
      chk(pass_en[1] == e_slow, "R4 slow slot", pass_en[1], e_slow);
      chk(busy == (m_st != 0), "R7 busy", busy, m_st != 0);
      chk(rate_rd == ((m_sh0 << 8) | m_sh1), "R8 shadow", rate_rd, (m_sh0 << 8) | m_sh1);
      if (last_ph % 32 == 0) wcnt_f = 0;
      if (last_ph == 0) wcnt_s = 0;
      wcnt_f += pass_en[0];
      wcnt_s += pass_en[1];
      if (last_ph % 32 == 31) chk(wcnt_f == wexp_f, "R2 fast window count", wcnt_f, wexp_f);
      if (last_ph == 63) chk(wcnt_s == wexp_s, "R4 slow frame count", wcnt_s, wexp_s);
    end
  end

  task automatic put(bit sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_at(int p, bit sel, logic [31:0] d);
    @(negedge clk);
    while (kcnt % 64 != p) @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(pass_en == 2'b00, "R1 reset pass_en", pass_en, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(rate_rd == 32'h0, "R1 reset readback", rate_rd, 0);
    rst = 1'b0;
    repeat (70) @(negedge clk);

    // R5: fields at [12:8] and [4:0], junk elsewhere ignored
    put_at(10, 1'b0, 32'hA5A5_E0E0 | (32'd5 << 8) | 32'd20);
    chk(rate_rd == 32'h0000_0514, "R5 field placement", rate_rd, 32'h514);
    // R9: command write without bit 31
    put(1'b1, 32'h7FFF_FFFF);
    chk(busy == 1'b0, "R9 no kick", busy, 0);
    // R6: kick
    put_at(20, 1'b1, 32'h8000_0000);
    chk(busy == 1'b1, "R6 kick raises busy", busy, 1);
    // R8: writes during busy ignored
    put(1'b0, 32'h0000_1F1F);
    put(1'b1, 32'h8000_0000);
    chk(rate_rd == 32'h0000_0514, "R8 rate write ignored", rate_rd, 32'h514);
    wait_idle();
    repeat (140) @(negedge clk);

    // extremes, kick landing on the frame-end edge
    put(1'b0, (32'd31 << 8) | 32'd0);
    put_at(63, 1'b1, 32'h8000_0000);
    put_at(63, 1'b0, 32'h0000_0303);   // lands while busy: ignored
    wait_idle();
    repeat (140) @(negedge clk);

    put(1'b0, (32'd0 << 8) | 32'd31);
    put_at(62, 1'b1, 32'h8000_0000);
    for (int k = 0; k < 3; k++) put_at(63, 1'b0, 32'h0000_0909); // some hit the busy-fall edge
    wait_idle();
    repeat (140) @(negedge clk);

    put(1'b0, (32'd16 << 8) | 32'd7);
    put(1'b1, 32'h8000_0000);
    wait_idle();
    repeat (200) @(negedge clk);
    chk(busy == 1'b0, "R7 idle at end", busy, 0);
    finish_up();
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule